// File: doc/BRIEF.md
# PLL Lock Detector

This block decides whether a phase-locked loop is in lock. For every comparison the phase detector makes, it gets a strobe and the distance, in prescaler clock cycles, between the reference edge and the feedback edge. A comparison is a hit when that distance falls inside a lock window, and the window can be narrow or wide. A one-bit flag reports the outcome of the latest comparison. A second flag reports sustained lock, and it is driven by a saturating event counter with hysteresis.

The counter has two modes. In restart mode any miss resets the counter to zero. In up/down mode hits count up and misses count down. A 2-bit accuracy code selects a pair of thresholds. The lock flag rises when the counter reaches the upper threshold and falls once the counter drops to the lower one, which sits 16 counts below. A synchronous, active-high reset clears the counter and both flags.

Top module: `lockdet_top`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, `lock_inst` and `lock_cont` all become 0 at that edge.
- R2: A comparison is a hit when `cmp_dist` < 2 with `wide_win`=0, or when `cmp_dist` < 4 with `wide_win`=1. At each edge where `cmp_valid` is high, `lock_inst` takes the hit value of that comparison.
- R3: At an edge where `cmp_valid` is low, the counter and both flags hold their values, whatever the other inputs carry.
- R4: With `cnt_mode`=0 (restart), a miss resets the counter to 0 and clears `lock_cont` at the same edge.
- R5: With `cnt_mode`=1 (up/down), a miss lowers the counter by one and stops at 0.
- R6: A hit raises the counter by one in either mode, up to the lock threshold selected by `acc_sel`. From that value on, further hits leave the counter at the threshold.
- R7: `lock_cont` rises at the comparison that brings the counter to the lock threshold. That threshold is 127, 255, 511 or 1023 for `acc_sel` = 0, 1, 2 or 3.
- R8: `lock_cont` falls at the comparison that brings the counter to the unlock threshold (lock threshold minus 16: 111, 239, 495, 1007) or below. Between the two thresholds it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | One phase comparison this cycle |
| cmp_dist | input | DIST_W | Edge distance in prescaler cycles |
| wide_win | input | 1 | 0: window span 2, 1: window span 4 |
| cnt_mode | input | 1 | 0: restart on miss, 1: up/down |
| acc_sel | input | 2 | Threshold pair select |
| lock_inst | output | 1 | Hit flag of the latest comparison |
| lock_cont | output | 1 | Counter-based lock with hysteresis |

## Verification
Several properties are checked on every cycle. The checker confirms that reset clears all state, that idle cycles hold it, and that a restart-mode miss clears the counter and the lock flag. It also checks the one-count step down in up/down mode, that the counter never passes the threshold on a hit, and that `lock_inst` follows the window rule. Every rise and fall of `lock_cont` is checked against the selected threshold. The bench is still needed for the full counting history: reaching lock after exactly 127 to 1023 hits, holding lock through 15 misses but not 16 in up/down mode, the clamp at the threshold, and the hysteresis band seen as a flag that does not move.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam int unsigned ACC_W       = 2;
  localparam int unsigned BASE_EXP    = 7;
  localparam int unsigned CNT_W       = BASE_EXP + (1 << ACC_W) - 1;
  localparam int unsigned HYST        = 16;
  localparam int unsigned NARROW_SPAN = 2;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [ACC_W-1:0] acc_t;

  typedef enum logic {
    MODE_RESTART = 1'b0,
    MODE_UPDOWN  = 1'b1
  } cnt_mode_e;

  // upper threshold: 2^(BASE_EXP+acc) - 1 (wraps to all ones at the top code)
  function automatic cnt_t lock_limit(acc_t acc);
    cnt_t one_hot;
    one_hot = cnt_t'(1) << (BASE_EXP + 32'(acc));
    return one_hot - cnt_t'(1);
  endfunction

  function automatic cnt_t unlock_limit(acc_t acc);
    return lock_limit(acc) - cnt_t'(HYST);
  endfunction

  function automatic int unsigned window_span(logic wide);
    return NARROW_SPAN << wide;
  endfunction

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int unsigned DIST_W = 4
) (
  input  logic [DIST_W-1:0] cmp_dist,
  input  logic              wide_win,
  output logic              hit
);
  always_comb begin
    hit = 32'(cmp_dist) < lockdet_pkg::window_span(wide_win);
  end
endmodule

// File: rtl/lockdet_counter.sv
module lockdet_counter
  import lockdet_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmp_valid,
  input  logic      hit,
  input  cnt_mode_e mode,
  input  cnt_t      lock_lim,
  output cnt_t      cnt_q,
  output cnt_t      cnt_d
);
  logic ev_hit;
  logic ev_miss;
  logic at_top;
  logic at_floor;

  assign ev_hit   = cmp_valid && hit;
  assign ev_miss  = cmp_valid && !hit;
  assign at_top   = cnt_q >= lock_lim;
  assign at_floor = cnt_q == '0;

  always_comb begin
    cnt_d = cnt_q;
    if (ev_hit) begin
      cnt_d = at_top ? lock_lim : cnt_q + cnt_t'(1);
    end else if (ev_miss) begin
      if (mode == MODE_RESTART) begin
        cnt_d = '0;
      end else begin
        cnt_d = at_floor ? '0 : cnt_q - cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lockdet_flags.sv
module lockdet_flags
  import lockdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmp_valid,
  input  logic hit,
  input  cnt_t cnt_d,
  input  cnt_t lock_lim,
  input  cnt_t unlock_lim,
  output logic lock_inst,
  output logic lock_cont
);
  logic reach_lock;
  logic reach_unlock;

  assign reach_lock   = cmp_valid && (cnt_d >= lock_lim);
  assign reach_unlock = cmp_valid && (cnt_d <= unlock_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_inst <= 1'b0;
      lock_cont <= 1'b0;
    end else begin
      if (cmp_valid) begin
        lock_inst <= hit;
      end
      if (reach_lock) begin
        lock_cont <= 1'b1;
      end else if (reach_unlock) begin
        lock_cont <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int unsigned DIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [DIST_W-1:0] cmp_dist,
  input  logic              wide_win,
  input  logic              cnt_mode,
  input  logic [ACC_W-1:0]  acc_sel,
  output logic              lock_inst,
  output logic              lock_cont
);
  logic      hit;
  cnt_t      cnt_q;
  cnt_t      cnt_d;
  cnt_t      lock_lim;
  cnt_t      unlock_lim;
  cnt_mode_e mode;

  assign mode       = cnt_mode_e'(cnt_mode);
  assign lock_lim   = lock_limit(acc_sel);
  assign unlock_lim = unlock_limit(acc_sel);

  lockdet_window #(.DIST_W(DIST_W)) u_window (
    .cmp_dist (cmp_dist),
    .wide_win (wide_win),
    .hit      (hit)
  );

  lockdet_counter u_counter (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .hit       (hit),
    .mode      (mode),
    .lock_lim  (lock_lim),
    .cnt_q     (cnt_q),
    .cnt_d     (cnt_d)
  );

  lockdet_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .cmp_valid  (cmp_valid),
    .hit        (hit),
    .cnt_d      (cnt_d),
    .lock_lim   (lock_lim),
    .unlock_lim (unlock_lim),
    .lock_inst  (lock_inst),
    .lock_cont  (lock_cont)
  );
endmodule

// File: rtl/lockdet_sva.sv
module lockdet_sva
  import lockdet_pkg::*;
#(
  parameter int unsigned DIST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic [DIST_W-1:0] cmp_dist,
  input logic              wide_win,
  input logic              cnt_mode,
  input logic [ACC_W-1:0]  acc_sel,
  input logic              hit,
  input cnt_t              cnt_q,
  input logic              lock_inst,
  input logic              lock_cont
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && !lock_inst && !lock_cont);

  assert_inst_window_R2: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> lock_inst == (32'($past(cmp_dist)) < window_span($past(wide_win))));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(cnt_q) && $stable(lock_inst) && $stable(lock_cont));

  assert_restart_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !hit && !cnt_mode) |=> (cnt_q == '0) && !lock_cont);

  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !hit && cnt_mode && cnt_q != '0) |=> cnt_q == $past(cnt_q) - cnt_t'(1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && hit) |=> cnt_q <= lock_limit($past(acc_sel)));

  assert_lock_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_cont) |-> cnt_q >= lock_limit($past(acc_sel)));

  assert_lock_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_cont) |-> cnt_q <= unlock_limit($past(acc_sel)));
endmodule

bind lockdet_top lockdet_sva #(.DIST_W(DIST_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .cmp_valid (cmp_valid),
  .cmp_dist  (cmp_dist),
  .wide_win  (wide_win),
  .cnt_mode  (cnt_mode),
  .acc_sel   (acc_sel),
  .hit       (hit),
  .cnt_q     (cnt_q),
  .lock_inst (lock_inst),
  .lock_cont (lock_cont)
);

// File: tb/test_lockdet_top.sv
`timescale 1ns/1ps
module test_lockdet_top;
  localparam int DIST_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmp_valid = 1'b0;
  logic [DIST_W-1:0] cmp_dist = '0;
  logic              wide_win = 1'b0;
  logic              cnt_mode = 1'b0;
  logic [1:0]        acc_sel = '0;
  logic              lock_inst;
  logic              lock_cont;

  int n_checks = 0;
  int n_fail   = 0;
  int m_cnt    = 0;
  bit m_inst   = 0;
  bit m_lock   = 0;

  always #2.5 clk = ~clk;

  lockdet_top #(.DIST_W(DIST_W)) i_lockdet_top (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_dist(cmp_dist),
    .wide_win(wide_win), .cnt_mode(cnt_mode), .acc_sel(acc_sel),
    .lock_inst(lock_inst), .lock_cont(lock_cont)
  );

  function automatic int up_thr(int a);
    return (128 << a) - 1;
  endfunction

  function automatic int down_thr(int a);
    return up_thr(a) - 16;
  endfunction

  function automatic bit in_win(int d, bit w);
    return w ? (d <= 3) : (d <= 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(int d, bit w, bit m, int a);
    bit h;
    h = in_win(d, w);
    m_inst = h;
    if (h) m_cnt = (m_cnt >= up_thr(a)) ? up_thr(a) : m_cnt + 1;
    else if (!m) m_cnt = 0;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    if (m_cnt >= up_thr(a)) m_lock = 1;
    else if (m_cnt <= down_thr(a)) m_lock = 0;
  endtask

  task automatic cmp(int d, bit w, bit m, int a, string tag);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_dist = DIST_W'(d); wide_win = w; cnt_mode = m; acc_sel = 2'(a);
    model_step(d, w, m, a);
    @(negedge clk);
    cmp_valid = 1'b0;
    check("R2 lock_inst", int'(lock_inst), int'(m_inst));
    check(tag, int'(lock_cont), int'(m_lock));
  endtask

  task automatic run(int n, int d, bit m, int a, string tag);
    for (int i = 0; i < n; i++) cmp(d, 1'b0, m, a, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_cnt = 0; m_inst = 0; m_lock = 0;
    check("R1 lock_inst", int'(lock_inst), 0);
    check("R1 lock_cont", int'(lock_cont), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 lock_inst", int'(lock_inst), 0);
    check("R1 lock_cont", int'(lock_cont), 0);

    // R2 window edges
    cmp(1, 1'b0, 1'b1, 0, "R2 cont");
    check("R2 narrow dist1 hit", int'(lock_inst), 1);
    cmp(2, 1'b0, 1'b1, 0, "R2 cont");
    check("R2 narrow dist2 miss", int'(lock_inst), 0);
    cmp(3, 1'b1, 1'b1, 0, "R2 cont");
    check("R2 wide dist3 hit", int'(lock_inst), 1);
    cmp(4, 1'b1, 1'b1, 0, "R2 cont");
    check("R2 wide dist4 miss", int'(lock_inst), 0);

    // R7 accuracy 0: 126 hits not locked, 127th locks
    do_reset();
    run(126, 0, 1'b0, 0, "R7 acc0 below");
    check("R7 not yet locked", int'(lock_cont), 0);
    cmp(0, 1'b0, 1'b0, 0, "R7 acc0 reach");
    check("R7 locked at 127", int'(lock_cont), 1);

    // R6 saturation, R5 step down, R8 hysteresis
    run(200, 0, 1'b0, 0, "R6 extra hits");
    run(15, 9, 1'b1, 0, "R5 down");
    check("R8 held at 112", int'(lock_cont), 1);
    cmp(9, 1'b0, 1'b1, 0, "R8 reach 111");
    check("R8 unlocked at 111", int'(lock_cont), 0);
    cmp(0, 1'b0, 1'b1, 0, "R8 band");
    check("R8 stays unlocked in band", int'(lock_cont), 0);

    // R3 idle cycles ignore inputs
    run(20, 0, 1'b1, 0, "R7 relock");
    check("R7 relocked", int'(lock_cont), 1);
    @(negedge clk); cmp_dist = 4'd9; cnt_mode = 1'b0; acc_sel = 2'd3;
    repeat (5) @(negedge clk);
    check("R3 idle lock_cont", int'(lock_cont), 1);
    check("R3 idle lock_inst", int'(lock_inst), 1);

    // R4 restart miss clears
    cmp(5, 1'b0, 1'b0, 0, "R4 restart miss");
    check("R4 cleared", int'(lock_cont), 0);
    run(126, 0, 1'b0, 0, "R4 recount");
    check("R4 counter restarted from 0", int'(lock_cont), 0);

    // R5 floor
    do_reset();
    run(5, 7, 1'b1, 0, "R5 floor");
    run(127, 0, 1'b1, 0, "R5 floor count");
    check("R5 floor held at 0", int'(lock_cont), 1);

    // R7 larger accuracy codes
    for (int a = 1; a < 4; a++) begin
      do_reset();
      run(up_thr(a) - 1, 1, 1'b1, a, "R7 acc below");
      check("R7 not locked one short", int'(lock_cont), 0);
      cmp(0, 1'b0, 1'b1, a, "R7 acc reach");
      check("R7 locked at threshold", int'(lock_cont), 1);
      run(15, 3, 1'b1, a, "R8 acc band");
      check("R8 held above unlock", int'(lock_cont), 1);
      cmp(3, 1'b0, 1'b1, a, "R8 acc unlock");
      check("R8 unlocked", int'(lock_cont), 0);
    end

    // random mix
    do_reset();
    begin
      int a = 0;
      bit m = 1'b1;
      for (int i = 0; i < 5000; i++) begin
        int d;
        bit w;
        if (i % 400 == 0) begin
          a = int'($urandom_range(0, 1));
          m = ($urandom_range(0, 3) != 0);
        end
        w = 1'($urandom_range(0, 1));
        d = ($urandom_range(0, 19) != 0) ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 15));
        cmp(d, w, m, a, "R8 random");
        if ($urandom_range(0, 9) == 0) begin
          @(negedge clk); cmp_dist = DIST_W'($urandom_range(0, 15));
          @(negedge clk);
          check("R3 random idle", int'(lock_cont), int'(m_lock));
        end
        if (i == 2500) do_reset();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule